// File: doc/BRIEF.md
# Noise-Shaped Fractional Duty Pulse Modulator

This block is a fixed-frequency, edge-aligned pulse width modulator. The on-time request is finer than one clock count. A free-running counter sets the carrier. Its length in clocks is the carrier period input, which is the clock frequency divided by the switching frequency. The on-time request is an unsigned fixed-point word. It has `CNT_W` integer bits above `FRAC_W` fractional bits. Each carrier cycle can only switch on a whole count, so the block picks an integer on-time for every cycle. The residue left by that rounding is fed back into later cycles. Over many cycles the average on-time therefore converges to the fractional request.

The residue can be shaped with a first-order or a second-order difference, chosen by a select input. The first-order form has error transfer (1 − z⁻¹). The second-order form has (1 − z⁻¹)² and pushes more of the rounding noise toward half the switching frequency, away from the control band. The integer on-time is clamped to the carrier length. The carried residue always comes from the unclamped value, so the stored error never grows without bound. The period, the request and the order are all sampled together at the counter wrap, so a cycle in progress is never altered. A one-clock strobe marks the first clock of every carrier cycle.

Top module: `ef_pwm`

## Requirements
- R1: While reset is asserted, and after it is released until the first carrier cycle begins, `pwm_o` and `cycle_start_o` are low. Reset clears the carried residue, so the first cycles after reset behave as if no earlier error existed.
- R2: Each carrier cycle lasts exactly P clocks, where P is the period latched for that cycle (P = 0 behaves as 1). `cycle_start_o` is high only on the first clock of each cycle.
- R3: Within a cycle, `pwm_o` is high for the first D clocks and low for the rest, where D is that cycle's integer on-time. D = P gives a pulse covering the whole cycle, D = 0 keeps the output low, and D = 1 gives a single-clock pulse.
- R4: The request word is unsigned. Bits [CNT_W+FRAC_W-1:FRAC_W] are whole counts and bits [FRAC_W-1:0] are the fraction. In first-order mode (select = 0), D(n) = floor(req + e(n−1)), where e is the fractional residue left over by the previous cycle's rounding.
- R5: In first-order mode a request of 14.5 counts gives on-times alternating 14 and 15. A request of 14.25 gives 14, 14, 14, 15 repeating.
- R6: In second-order mode (select = 1), D(n) = floor(req + 2·e(n−1) − e(n−2)), and the new residue is the fractional part of the same sum.
- R7: D is clamped to the range 0..P. The residue stored for later cycles is taken from the unclamped sum.
- R8: Period, request and order are sampled only at the counter wrap. Changing them during a cycle does not change that cycle's length or on-time.
- R9: With a constant unclamped request, the total on-time over M cycles stays within 1 count of M·req in first-order mode and within 3 counts in second-order mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| carrier_period_i | input | CNT_W | Carrier length in clocks |
| on_time_i | input | CNT_W+FRAC_W | Fixed-point on-time request in counts |
| order_sel_i | input | 1 | Error-feedback order: 0 first, 1 second |
| pwm_o | output | 1 | Modulated output, registered |
| cycle_start_o | output | 1 | High on the first clock of each carrier cycle |

## Verification
Several properties are checked on every clock. The counter stays inside the latched period. The on-time never exceeds the period, and neither changes except at a cycle start. The strobe coincides with a zero count. Every falling edge of the output inside a cycle lands on the count equal to the on-time. Only the bench's scenarios can show the arithmetic of the feedback. They cover the 14/15 alternation, the three-to-one pattern, the second-order sequence, clamping in both directions with the residue taken from the unclamped sum, and the long-run average. An independent per-cycle model checks each of these. The scenarios also show that inputs changed mid-cycle take effect only from the next cycle, and that a reset mid-run clears the carried residue.

// File: rtl/ef_pwm_pkg.sv
package ef_pwm_pkg;

  typedef enum logic {
    ORD_FIRST  = 1'b0,
    ORD_SECOND = 1'b1
  } shape_order_e;

  // extra headroom bits on the feedback accumulator: sign plus 2*e growth
  localparam int ACC_GUARD = 3;

endpackage

// File: rtl/ef_pwm_timebase.sv
module ef_pwm_timebase #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  output logic             wrap_o,
  output logic [CNT_W-1:0] cnt_q_o,
  output logic [CNT_W-1:0] cnt_d_o,
  output logic [CNT_W-1:0] period_q_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] period_q, period_d;
  logic [CNT_W:0]   cnt_inc;
  logic             wrap;

  always_comb begin
    cnt_inc  = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    wrap     = (cnt_inc >= {1'b0, period_q});
    cnt_d    = wrap ? '0 : cnt_inc[CNT_W-1:0];
    period_d = wrap ? period_i : period_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      period_q <= '0;
    end else begin
      cnt_q    <= cnt_d;
      period_q <= period_d;
    end
  end

  assign wrap_o     = wrap;
  assign cnt_q_o    = cnt_q;
  assign cnt_d_o    = cnt_d;
  assign period_q_o = period_q;

endmodule

// File: rtl/ef_pwm_quant.sv
module ef_pwm_quant #(
  parameter int CNT_W  = 12,
  parameter int FRAC_W = 4,
  parameter int ACC_W  = CNT_W + FRAC_W + 3
) (
  input  logic signed [ACC_W-1:0] acc_i,
  input  logic        [CNT_W-1:0] limit_i,
  output logic        [CNT_W-1:0] duty_o,
  output logic        [FRAC_W-1:0] resid_o
);

  logic signed [ACC_W-1:0] whole_s;
  logic signed [ACC_W-1:0] limit_s;

  always_comb begin
    whole_s = acc_i >>> FRAC_W;
    limit_s = signed'({{(ACC_W-CNT_W){1'b0}}, limit_i});
    resid_o = acc_i[FRAC_W-1:0];
    if (whole_s[ACC_W-1]) begin
      duty_o = '0;
    end else if (whole_s > limit_s) begin
      duty_o = limit_i;
    end else begin
      duty_o = whole_s[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/ef_pwm_shaper.sv
module ef_pwm_shaper
  import ef_pwm_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int FRAC_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic [CNT_W+FRAC_W-1:0] req_i,
  input  shape_order_e            order_i,
  input  logic [CNT_W-1:0]        limit_i,
  output logic [CNT_W-1:0]        duty_q_o,
  output logic [CNT_W-1:0]        duty_d_o
);

  localparam int REQ_W = CNT_W + FRAC_W;
  localparam int ACC_W = REQ_W + ACC_GUARD;

  logic [FRAC_W-1:0]       e1_q, e1_d, e2_q, e2_d;
  logic [CNT_W-1:0]        duty_q, duty_d;
  logic signed [ACC_W-1:0] e1_s, e2_s, fb_s, acc_s;
  logic [CNT_W-1:0]        duty_new;
  logic [FRAC_W-1:0]       resid_new;

  always_comb begin
    e1_s = signed'({{(ACC_W-FRAC_W){1'b0}}, e1_q});
    e2_s = signed'({{(ACC_W-FRAC_W){1'b0}}, e2_q});
    if (order_i == ORD_SECOND) begin
      fb_s = (e1_s <<< 1) - e2_s;
    end else begin
      fb_s = e1_s;
    end
    acc_s = signed'({{ACC_GUARD{1'b0}}, req_i}) + fb_s;
  end

  ef_pwm_quant #(
    .CNT_W (CNT_W),
    .FRAC_W(FRAC_W),
    .ACC_W (ACC_W)
  ) quant_i (
    .acc_i  (acc_s),
    .limit_i(limit_i),
    .duty_o (duty_new),
    .resid_o(resid_new)
  );

  always_comb begin
    duty_d = duty_q;
    e1_d   = e1_q;
    e2_d   = e2_q;
    if (load_i) begin
      duty_d = duty_new;
      e1_d   = resid_new;
      e2_d   = e1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      e1_q   <= '0;
      e2_q   <= '0;
    end else begin
      duty_q <= duty_d;
      e1_q   <= e1_d;
      e2_q   <= e2_d;
    end
  end

  assign duty_q_o = duty_q;
  assign duty_d_o = duty_d;

endmodule

// File: rtl/ef_pwm_outstage.sv
module ef_pwm_outstage #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_d_i,
  input  logic [CNT_W-1:0] duty_d_i,
  input  logic             wrap_i,
  output logic             pwm_o,
  output logic             start_o
);

  logic pwm_q, pwm_d;
  logic start_q, start_d;

  always_comb begin
    pwm_d   = (cnt_d_i < duty_d_i);
    start_d = wrap_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      pwm_q   <= pwm_d;
      start_q <= start_d;
    end
  end

  assign pwm_o   = pwm_q;
  assign start_o = start_q;

endmodule

// File: rtl/ef_pwm.sv
module ef_pwm
  import ef_pwm_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int FRAC_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CNT_W-1:0]        carrier_period_i,
  input  logic [CNT_W+FRAC_W-1:0] on_time_i,
  input  logic                    order_sel_i,
  output logic                    pwm_o,
  output logic                    cycle_start_o
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_sync_n;
  logic                   wrap;
  logic [CNT_W-1:0]       cnt_q, cnt_d, period_q;
  logic [CNT_W-1:0]       duty_q, duty_d;
  shape_order_e           order_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];
  assign order_sel  = shape_order_e'(order_sel_i);

  ef_pwm_timebase #(.CNT_W(CNT_W)) timebase_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .period_i  (carrier_period_i),
    .wrap_o    (wrap),
    .cnt_q_o   (cnt_q),
    .cnt_d_o   (cnt_d),
    .period_q_o(period_q)
  );

  ef_pwm_shaper #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) shaper_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_i  (wrap),
    .req_i   (on_time_i),
    .order_i (order_sel),
    .limit_i (carrier_period_i),
    .duty_q_o(duty_q),
    .duty_d_o(duty_d)
  );

  ef_pwm_outstage #(.CNT_W(CNT_W)) outstage_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cnt_d_i (cnt_d),
    .duty_d_i(duty_d),
    .wrap_i  (wrap),
    .pwm_o   (pwm_o),
    .start_o (cycle_start_o)
  );

endmodule

// File: rtl/ef_pwm_chk.sv
module ef_pwm_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwm_o,
  input logic             cycle_start_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] duty_q,
  input logic [CNT_W-1:0] period_q
);

  // R2
  cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_q == '0) ? (cnt_q == '0) : (cnt_q < period_q));

  // R2
  start_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start_o |-> (cnt_q == '0));

  // R7
  duty_clamped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    duty_q <= period_q);

  // R8
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_start_o |-> ($stable(duty_q) && $stable(period_q)));

  // R3
  fall_at_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pwm_o) && !cycle_start_o) |-> (cnt_q == duty_q));

  // R3
  start_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start_o |-> (pwm_o == (duty_q != '0)));

endmodule

bind ef_pwm ef_pwm_chk #(.CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .pwm_o        (pwm_o),
  .cycle_start_o(cycle_start_o),
  .cnt_q        (cnt_q),
  .duty_q       (duty_q),
  .period_q     (period_q)
);

// File: tb/ef_pwm_tb.sv
module ef_pwm_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 12;
  localparam int FRAC_W     = 4;
  localparam int QSTEP      = 1 << FRAC_W;
  localparam int NVEC       = 11;

  typedef struct packed {
    logic [11:0] per;
    logic [15:0] req;
    logic        ord;
    logic [7:0]  ncyc;
    logic [3:0]  rq;
  } vec_t;

  // req in 1/16 counts; rq is the requirement number the vector targets
  localparam vec_t VECS [NVEC] = '{
    '{12'd40, 16'd232, 1'b0, 8'd9,  4'd5},
    '{12'd40, 16'd228, 1'b0, 8'd9,  4'd5},
    '{12'd40, 16'd640, 1'b0, 8'd4,  4'd3},
    '{12'd40, 16'd0,   1'b0, 8'd4,  4'd3},
    '{12'd40, 16'd16,  1'b0, 8'd4,  4'd3},
    '{12'd20, 16'd165, 1'b1, 8'd17, 4'd6},
    '{12'd20, 16'd400, 1'b1, 8'd5,  4'd7},
    '{12'd20, 16'd0,   1'b1, 8'd4,  4'd7},
    '{12'd50, 16'd124, 1'b1, 8'd13, 4'd6},
    '{12'd12, 16'd49,  1'b0, 8'd17, 4'd4},
    '{12'd7,  16'd100, 1'b1, 8'd9,  4'd2}
  };

  logic              clk;
  logic              rst_n;
  logic [CNT_W-1:0]  per_i;
  logic [15:0]       req_i;
  logic              ord_i;
  logic              pwm_o;
  logic              start_o;

  int n_chk;
  int n_bad;
  int m_e1;
  int m_e2;
  int exp_d;
  int exp_len;

  ef_pwm #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .carrier_period_i(per_i),
    .on_time_i       (req_i),
    .order_sel_i     (ord_i),
    .pwm_o           (pwm_o),
    .cycle_start_o   (start_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  function automatic string rq_name(input int r);
    return $sformatf("R%0d", r);
  endfunction

  // independent per-cycle model of the feedback rule in R4/R6/R7
  task automatic model_step(input int per, input int req, input bit ord, output int d, output int len);
    int v;
    int y;
    v = ord ? (req + 2 * m_e1 - m_e2) : (req + m_e1);
    y = v >>> FRAC_W;
    m_e2 = m_e1;
    m_e1 = v - y * QSTEP;
    if (y < 0) d = 0;
    else if (y > per) d = per;
    else d = y;
    len = (per == 0) ? 1 : per;
  endtask

  task automatic wait_start();
    do @(negedge clk); while (!start_o);
  endtask

  // called at a negedge on a cycle's first clock; returns on the next one
  task automatic measure(output int hi, output int len);
    hi  = int'(pwm_o);
    len = 1;
    forever begin
      @(negedge clk);
      if (start_o) break;
      hi += int'(pwm_o);
      len++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R2 watchdog: actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int hi;
    int len;
    int sum;
    int ncnt;
    int lim;
    n_chk = 0;
    n_bad = 0;
    m_e1  = 0;
    m_e2  = 0;
    rst_n = 1'b0;
    per_i = VECS[0].per;
    req_i = VECS[0].req;
    ord_i = VECS[0].ord;
    repeat (3) @(negedge clk);
    // R1 outputs low in reset
    check(pwm_o == 1'b0, "R1 pwm in reset", int'(pwm_o), 0);
    check(start_o == 1'b0, "R1 start in reset", int'(start_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pwm_o == 1'b0 && start_o == 1'b0, "R1 idle after release", int'({pwm_o, start_o}), 0);
    wait_start();
    model_step(VECS[0].per, VECS[0].req, VECS[0].ord, exp_d, exp_len);

    for (int v = 0; v < NVEC; v++) begin
      sum  = 0;
      ncnt = 0;
      for (int c = 0; c < int'(VECS[v].ncyc); c++) begin
        // new inputs mid-cycle: only the next wrap may take them (R8)
        per_i = VECS[v].per;
        req_i = VECS[v].req;
        ord_i = VECS[v].ord;
        measure(hi, len);
        if (c == 0) begin
          check(hi == exp_d, "R8 on-time held", hi, exp_d);
          check(len == exp_len, "R8 length held", len, exp_len);
        end else begin
          check(hi == exp_d, {rq_name(int'(VECS[v].rq)), " on-time"}, hi, exp_d);
          check(len == exp_len, "R2 cycle length", len, exp_len);
          sum += hi;
          ncnt++;
        end
        model_step(VECS[v].per, VECS[v].req, VECS[v].ord, exp_d, exp_len);
      end
      // R9 long-run average where no clamping can occur
      if (VECS[v].req >= 16'(QSTEP) && int'(VECS[v].req) <= (int'(VECS[v].per) - 2) * QSTEP) begin
        lim = VECS[v].ord ? 3 * QSTEP : QSTEP;
        check((sum * QSTEP - ncnt * int'(VECS[v].req)) <= lim &&
              (ncnt * int'(VECS[v].req) - sum * QSTEP) <= lim,
              "R9 average x16", sum * QSTEP, ncnt * int'(VECS[v].req));
      end
    end

    // mid-run reset clears residue; 14.25 restarts as 14,14,14,15 (R1, R5)
    per_i = 12'd40;
    req_i = 16'd228;
    ord_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(pwm_o == 1'b0, "R1 pwm after mid-run reset", int'(pwm_o), 0);
    check(start_o == 1'b0, "R1 start after mid-run reset", int'(start_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    wait_start();
    for (int c = 0; c < 8; c++) begin
      measure(hi, len);
      check(hi == (((c % 4) == 3) ? 15 : 14), "R1 residue cleared pattern", hi, ((c % 4) == 3) ? 15 : 14);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule